// File: doc/BRIEF.md
# PS/2 Mouse Device Port

This block is the device end of a PS/2 mouse link. Upstream logic gives it one relative movement sample at a time: an X and a Y magnitude, a direction flag for each axis, and the left and right button states. The block packs the sample into the three-byte mouse movement report and shifts the bytes out on the two open-collector wires. The block makes the wire clock itself. Each wire is modelled as a pull-down enable output plus a sensed input, so the pad ring needs only an open-drain buffer and a pull-up.

The same wires carry the host's start-up commands. When the host holds data low and releases the clock, the block clocks in one command byte and drives the line-level acknowledge bit. It then answers the two start-up commands with an acknowledge byte. After reset, and after the set-defaults command, the port is silent. It begins to stream reports only once it has acknowledged the enable command. A one-cycle ready pulse after each complete report tells upstream logic that it may present the next sample.

Before each data bit, the block checks whether the host is holding the clock low. If so, it gives the byte up, waits until both wires have been idle for a set time, and sends the byte again from its start bit.

Top module: `ps2_mouse_device`

## Requirements
- R1: After reset both pull-down enables are 0 and `mv_ready` is 0. The port starts disabled, so a `mv_load` pulse produces no frame and no ready pulse.
- R2: Every byte the device sends is an 11-bit frame: start bit 0, then the 8 data bits with the least significant bit first, then an odd parity bit (the data bits plus parity hold an odd number of ones), then stop bit 1.
- R3: The device makes the clock. For each bit it releases the clock for `HALF_CYC` cycles with the bit already placed on data, then pulls the clock low for exactly `HALF_CYC` cycles. Data does not change while the device holds the clock low.
- R4: Host byte 0xF6 is answered with the byte 0xFA and leaves the port disabled. Host byte 0xF4 is answered with 0xFA, and only after that are movement reports sent.
- R5: Receiving a host byte: the device gives 11 clock pulses and samples data at the end of each high phase of pulses 1 to 10 (data bits least significant first, then parity, then stop). During pulse 11 it pulls data low as the line acknowledge. A byte with wrong parity, or any value other than 0xF6 and 0xF4, gets no reply byte and leaves the enable state unchanged.
- R6: A report is three frames in this order: a header `{Yovf, Xovf, Yneg, Xneg, 1, 0, right, left}` (bit 7 first), then the X byte, then the Y byte.
- R7: An axis whose magnitude is 256 or more sets its overflow bit in the header and sends 0xFF as its movement byte. Overflow is not carried over: the next report sets it only from its own sample.
- R8: If the host holds the clock low when a bit's released phase ends, the device releases both wires at once. It then resends that whole byte once both wires have stayed high for `GAP_CYC` cycles, and the report still completes with all three bytes.
- R9: `mv_ready` is a one-cycle pulse that follows the third frame of a report. It does not pulse for acknowledge bytes. A `mv_load` that arrives while a report is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mv_load | input | 1 | One-cycle strobe that offers a movement sample |
| mv_dx | input | MAG_W | X movement magnitude |
| mv_dy | input | MAG_W | Y movement magnitude |
| mv_xneg | input | 1 | X direction flag (1 = negative) |
| mv_yneg | input | 1 | Y direction flag (1 = negative) |
| btn_left | input | 1 | Left button held |
| btn_right | input | 1 | Right button held |
| mv_ready | output | 1 | One-cycle pulse after a report has gone out |
| ps2_clk_in | input | 1 | Sensed level of the clock wire |
| ps2_dat_in | input | 1 | Sensed level of the data wire |
| ps2_clk_oe | output | 1 | Pull the clock wire low when 1 |
| ps2_dat_oe | output | 1 | Pull the data wire low when 1 |

## Verification
The bench acts as the host, decodes every device frame from the wire levels and checks its format and low-phase timing. The corner cases it targets are these:
- Reports before the enable acknowledge, which a port that ignored the enable gate would leak.
- Commands with bad parity or unknown values, which a careless decoder would acknowledge with a byte.
- Magnitudes at and above 256, where a missing overflow path would send a wrapped count.
- A sticky overflow bit, which would mark the report that follows.
- A host clock inhibit in the middle of a byte. A design that missed it would keep clocking against the host, or would resume mid-byte and so corrupt or drop a report byte.

It also offers a second sample during a report. A port that accepted it would emit extra frames or extra ready pulses.

// File: rtl/ps2m_pkg.sv
`timescale 1ns/1ps
package ps2m_pkg;
  localparam logic [7:0] ACK_BYTE     = 8'hFA;
  localparam logic [7:0] CMD_DEFAULTS = 8'hF6;
  localparam logic [7:0] CMD_ENABLE   = 8'hF4;
  localparam int         FRAME_BITS   = 11;

  typedef enum logic [1:0] {LN_IDLE, LN_SETUP, LN_LOW, LN_HIGH} line_st_e;

  function automatic logic odd_parity(input logic [7:0] b);
    return ~(^b);
  endfunction
endpackage

// File: rtl/ps2m_tx.sv
`timescale 1ns/1ps
module ps2m_tx
  import ps2m_pkg::*;
#(
  parameter int HALF_CYC = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] byte_in,
  input  logic       clk_in,
  output logic       clk_oe,
  output logic       dat_oe,
  output logic       done,
  output logic       abort
);
  localparam int CNT_W = $clog2(HALF_CYC) + 1;
  localparam int IDX_W = $clog2(FRAME_BITS);

  line_st_e              st_q, st_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [FRAME_BITS-1:0] frm_q, frm_d;
  logic                  phase_end;

  assign phase_end = (cnt_q == CNT_W'(HALF_CYC - 1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    frm_d = frm_q;
    done  = 1'b0;
    abort = 1'b0;
    case (st_q)
      LN_IDLE: if (start) begin
        frm_d = {1'b1, odd_parity(byte_in), byte_in, 1'b0};
        idx_d = '0;
        cnt_d = '0;
        st_d  = LN_SETUP;
      end
      LN_SETUP: if (phase_end) begin
        cnt_d = '0;
        if (!clk_in) begin
          abort = 1'b1;
          st_d  = LN_IDLE;
        end else begin
          st_d = LN_LOW;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      LN_LOW: if (phase_end) begin
        cnt_d = '0;
        frm_d = frm_q >> 1;
        if (idx_q == IDX_W'(FRAME_BITS - 1)) begin
          done = 1'b1;
          st_d = LN_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
          st_d  = LN_SETUP;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      default: st_d = LN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LN_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      frm_q <= '1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      frm_q <= frm_d;
    end
  end

  assign clk_oe = (st_q == LN_LOW);
  assign dat_oe = ((st_q == LN_SETUP) || (st_q == LN_LOW)) && !frm_q[0];

  // R3: the bit on the wire holds for the whole driven-low clock phase
  assert_dat_stable_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_oe && $past(clk_oe)) |-> $stable(dat_oe));

  // R8: a given-up frame lets go of both wires on the next cycle
  assert_abort_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!clk_oe && !dat_oe));
endmodule

// File: rtl/ps2m_rx.sv
`timescale 1ns/1ps
module ps2m_rx
  import ps2m_pkg::*;
#(
  parameter int HALF_CYC = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       dat_in,
  output logic       clk_oe,
  output logic       dat_oe,
  output logic       done,
  output logic [7:0] byte_out,
  output logic       ok
);
  localparam int CNT_W = $clog2(HALF_CYC) + 1;
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam int SMP_N = FRAME_BITS - 1;

  line_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [SMP_N-1:0] sh_q, sh_d;
  logic             phase_end, last_pulse;

  assign phase_end  = (cnt_q == CNT_W'(HALF_CYC - 1));
  assign last_pulse = (idx_q == IDX_W'(SMP_N));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    done  = 1'b0;
    case (st_q)
      LN_IDLE: if (start) begin
        idx_d = '0;
        cnt_d = '0;
        st_d  = LN_LOW;
      end
      LN_LOW: if (phase_end) begin
        cnt_d = '0;
        st_d  = LN_HIGH;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      LN_HIGH: if (phase_end) begin
        cnt_d = '0;
        if (last_pulse) begin
          done = 1'b1;
          st_d = LN_IDLE;
        end else begin
          sh_d  = {dat_in, sh_q[SMP_N-1:1]};
          idx_d = idx_q + 1'b1;
          st_d  = LN_LOW;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      default: st_d = LN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LN_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
    end
  end

  assign clk_oe   = (st_q == LN_LOW);
  assign dat_oe   = (st_q != LN_IDLE) && last_pulse;
  assign byte_out = sh_q[7:0];
  assign ok       = sh_q[SMP_N-1] && (sh_q[8] == odd_parity(sh_q[7:0]));

  // R5: the line acknowledge starts together with a driven-low clock phase
  assert_ack_in_last_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_oe) |-> clk_oe);
endmodule

// File: rtl/ps2m_seq.sv
`timescale 1ns/1ps
module ps2m_seq
  import ps2m_pkg::*;
#(
  parameter int MAG_W   = 10,
  parameter int GAP_CYC = 2500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mv_load,
  input  logic [MAG_W-1:0] mv_dx,
  input  logic [MAG_W-1:0] mv_dy,
  input  logic             mv_xneg,
  input  logic             mv_yneg,
  input  logic             btn_left,
  input  logic             btn_right,
  input  logic             clk_in,
  input  logic             dat_in,
  input  logic             tx_done,
  input  logic             tx_abort,
  input  logic             rx_done,
  input  logic [7:0]       rx_byte,
  input  logic             rx_ok,
  output logic             tx_start,
  output logic [7:0]       tx_byte,
  output logic             rx_start,
  output logic             mv_ready
);
  localparam int GAP_W = $clog2(GAP_CYC) + 1;

  typedef enum logic [1:0] {SQ_IDLE, SQ_GAP, SQ_SEND, SQ_RECV} seq_st_e;

  seq_st_e          st_q, st_d;
  logic             en_q, en_d, ackp_q, ackp_d, sack_q, sack_d, rdy_d;
  logic [1:0]       bidx_q, bidx_d;
  logic [7:0]       b0_q, b0_d, b1_q, b1_d, b2_q, b2_d, rb;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             host_req, lines_idle, x_ovf, y_ovf;

  assign host_req   = clk_in && !dat_in;
  assign lines_idle = clk_in && dat_in;
  assign x_ovf      = |mv_dx[MAG_W-1:8];
  assign y_ovf      = |mv_dy[MAG_W-1:8];

  always_comb begin
    st_d = st_q; en_d = en_q; ackp_d = ackp_q; sack_d = sack_q;
    bidx_d = bidx_q; b0_d = b0_q; b1_d = b1_q; b2_d = b2_q; gap_d = gap_q;
    rdy_d = 1'b0; tx_start = 1'b0; rx_start = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        gap_d = '0;
        if (host_req) begin
          rx_start = 1'b1;
          st_d     = SQ_RECV;
        end else if (ackp_q) begin
          sack_d = 1'b1;
          st_d   = SQ_GAP;
        end else if (en_q && mv_load) begin
          b0_d   = {y_ovf, x_ovf, mv_yneg, mv_xneg, 1'b1, 1'b0, btn_right, btn_left};
          b1_d   = x_ovf ? 8'hFF : mv_dx[7:0];
          b2_d   = y_ovf ? 8'hFF : mv_dy[7:0];
          bidx_d = '0;
          sack_d = 1'b0;
          st_d   = SQ_GAP;
        end
      end
      SQ_GAP: begin
        if (host_req) begin
          rx_start = 1'b1;
          ackp_d   = 1'b0;
          rdy_d    = !sack_q;
          st_d     = SQ_RECV;
        end else if (!lines_idle) begin
          gap_d = '0;
        end else if (gap_q == GAP_W'(GAP_CYC - 1)) begin
          tx_start = 1'b1;
          gap_d    = '0;
          st_d     = SQ_SEND;
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
      SQ_SEND: begin
        if (tx_abort) begin
          st_d = SQ_GAP;
        end else if (tx_done) begin
          if (sack_q) begin
            ackp_d = 1'b0;
            st_d   = SQ_IDLE;
          end else if (bidx_q == 2'd2) begin
            rdy_d = 1'b1;
            st_d  = SQ_IDLE;
          end else begin
            bidx_d = bidx_q + 1'b1;
            st_d   = SQ_GAP;
          end
        end
      end
      SQ_RECV: if (rx_done) begin
        st_d = SQ_IDLE;
        if (rx_ok && rx_byte == CMD_DEFAULTS) begin
          en_d = 1'b0; ackp_d = 1'b1;
        end else if (rx_ok && rx_byte == CMD_ENABLE) begin
          en_d = 1'b1; ackp_d = 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    unique case (bidx_q)
      2'd0:    rb = b0_q;
      2'd1:    rb = b1_q;
      default: rb = b2_q;
    endcase
  end
  assign tx_byte = sack_q ? ACK_BYTE : rb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE; en_q <= 1'b0; ackp_q <= 1'b0; sack_q <= 1'b0;
      bidx_q <= '0; b0_q <= '0; b1_q <= '0; b2_q <= '0; gap_q <= '0;
      mv_ready <= 1'b0;
    end else begin
      st_q <= st_d; en_q <= en_d; ackp_q <= ackp_d; sack_q <= sack_d;
      bidx_q <= bidx_d; b0_q <= b0_d; b1_q <= b1_d; b2_q <= b2_d; gap_q <= gap_d;
      mv_ready <= rdy_d;
    end
  end

  // R9: the ready strobe lasts a single cycle
  assert_ready_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mv_ready |=> !mv_ready);

  // R4: a report byte is started only while the port is enabled
  assert_report_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !sack_q) |-> en_q);
endmodule

// File: rtl/ps2_mouse_device.sv
`timescale 1ns/1ps
module ps2_mouse_device #(
  parameter int HALF_CYC = 5000,
  parameter int GAP_CYC  = 2500,
  parameter int MAG_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mv_load,
  input  logic [MAG_W-1:0] mv_dx,
  input  logic [MAG_W-1:0] mv_dy,
  input  logic             mv_xneg,
  input  logic             mv_yneg,
  input  logic             btn_left,
  input  logic             btn_right,
  output logic             mv_ready,
  input  logic             ps2_clk_in,
  input  logic             ps2_dat_in,
  output logic             ps2_clk_oe,
  output logic             ps2_dat_oe
);
  logic       rst_meta, rst_sync;
  logic       tx_start, tx_done, tx_abort, tx_clk_oe, tx_dat_oe;
  logic       rx_start, rx_done, rx_ok, rx_clk_oe, rx_dat_oe;
  logic [7:0] tx_byte, rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  ps2m_seq #(.MAG_W(MAG_W), .GAP_CYC(GAP_CYC)) seq_i (
    .clk(clk), .rst_n(rst_sync), .mv_load(mv_load), .mv_dx(mv_dx), .mv_dy(mv_dy),
    .mv_xneg(mv_xneg), .mv_yneg(mv_yneg), .btn_left(btn_left), .btn_right(btn_right),
    .clk_in(ps2_clk_in), .dat_in(ps2_dat_in), .tx_done(tx_done), .tx_abort(tx_abort),
    .rx_done(rx_done), .rx_byte(rx_byte), .rx_ok(rx_ok), .tx_start(tx_start),
    .tx_byte(tx_byte), .rx_start(rx_start), .mv_ready(mv_ready)
  );

  ps2m_tx #(.HALF_CYC(HALF_CYC)) tx_i (
    .clk(clk), .rst_n(rst_sync), .start(tx_start), .byte_in(tx_byte),
    .clk_in(ps2_clk_in), .clk_oe(tx_clk_oe), .dat_oe(tx_dat_oe),
    .done(tx_done), .abort(tx_abort)
  );

  ps2m_rx #(.HALF_CYC(HALF_CYC)) rx_i (
    .clk(clk), .rst_n(rst_sync), .start(rx_start), .dat_in(ps2_dat_in),
    .clk_oe(rx_clk_oe), .dat_oe(rx_dat_oe), .done(rx_done),
    .byte_out(rx_byte), .ok(rx_ok)
  );

  assign ps2_clk_oe = tx_clk_oe | rx_clk_oe;
  assign ps2_dat_oe = tx_dat_oe | rx_dat_oe;

  // R3: at most one direction generates the wire clock at any time
  assert_single_clock_source_R3: assert property (@(posedge clk) disable iff (!rst_sync)
    !(tx_clk_oe && rx_clk_oe));
endmodule

// File: tb/ps2_mouse_device_tb.sv
`timescale 1ns/1ps
module ps2_mouse_device_tb_top;
  localparam int HALF = 6;
  localparam int GAP  = 8;
  localparam int MW   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mv_load = 1'b0, mv_xneg = 1'b0, mv_yneg = 1'b0, btn_l = 1'b0, btn_r = 1'b0;
  logic [MW-1:0] mv_dx = '0, mv_dy = '0;
  logic mv_ready, ps2_clk_oe, ps2_dat_oe;
  logic host_clk_low = 1'b0, host_dat_low = 1'b0;
  wire  ps2c = !(ps2_clk_oe || host_clk_low);
  wire  ps2d = !(ps2_dat_oe || host_dat_low);

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;
  bit host_mode = 1'b0, mon_ignore = 1'b0;
  int mon_bitn = 0, lowlen = 0, total_bytes = 0, ready_cnt = 0, ready_bytes = 0;
  bit pc = 1'b1, lowdat = 1'b0, len_err = 1'b0, stab_err = 1'b0;
  logic [10:0] fbits;
  logic [7:0] rxq[$];

  always #4 clk = !clk;

  ps2_mouse_device #(.HALF_CYC(HALF), .GAP_CYC(GAP), .MAG_W(MW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mv_load(mv_load), .mv_dx(mv_dx), .mv_dy(mv_dy),
    .mv_xneg(mv_xneg), .mv_yneg(mv_yneg), .btn_left(btn_l), .btn_right(btn_r),
    .mv_ready(mv_ready), .ps2_clk_in(ps2c), .ps2_dat_in(ps2d),
    .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  // Host-side reference model: decodes device frames from the wire levels every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (host_mode || mon_ignore) begin
        mon_bitn = 0; len_err = 0; stab_err = 0;
      end else if (!ps2c && pc) begin
        fbits[mon_bitn] = ps2d;
        mon_bitn++;
        lowlen = 1;
        lowdat = ps2d;
      end else if (!ps2c && mon_bitn > 0) begin
        lowlen++;
        if (ps2d != lowdat) stab_err = 1;
      end else if (ps2c && !pc && mon_bitn > 0) begin
        if (lowlen != HALF) len_err = 1;
        if (mon_bitn == 11) begin
          chk(fbits[0] == 1'b0 && fbits[10] == 1'b1 && (^fbits[9:1]) == 1'b1,
              "R2", "frame start/parity/stop", int'(fbits), int'(fbits));
          chk(!len_err && !stab_err, "R3", "low phase length and data stability",
              int'({len_err, stab_err}), 0);
          rxq.push_back(fbits[8:1]);
          total_bytes++;
          mon_bitn = 0; len_err = 0; stab_err = 0;
        end
      end
      pc = ps2c;
      if (mv_ready) begin
        ready_cnt++;
        ready_bytes = total_bytes;
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [MW-1:0] dx, input logic [MW-1:0] dy,
                      input bit xn, input bit yn, input bit l, input bit r);
    @(posedge clk); #1;
    mv_dx = dx; mv_dy = dy; mv_xneg = xn; mv_yneg = yn; btn_l = l; btn_r = r; mv_load = 1'b1;
    @(posedge clk); #1;
    mv_load = 1'b0;
  endtask

  task automatic host_send(input logic [7:0] b, input bit good_par);
    logic [9:0] bits;
    bits = {1'b1, (~^b) ^ !good_par, b};
    host_mode = 1;
    @(posedge clk); #1 host_clk_low = 1'b1;
    repeat (12) @(posedge clk);
    #1 host_dat_low = 1'b1;
    repeat (2) @(posedge clk);
    #1 host_clk_low = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge ps2c);
      #1 host_dat_low = !bits[k];
    end
    @(negedge ps2c);
    cycles(HALF / 2);
    chk(ps2_dat_oe == 1'b1, "R5", "line acknowledge in pulse 11", int'(ps2_dat_oe), 1);
    @(posedge ps2c);
    cycles(HALF + 2);
    host_mode = 0;
  endtask

  task automatic expect_one(input logic [7:0] e, input string req, input string what);
    int t = 0;
    while (rxq.size() == 0 && t < 2000) begin cycles(1); t++; end
    if (rxq.size() == 0) chk(1'b0, req, {what, " (no frame)"}, -1, int'(e));
    else begin
      logic [7:0] a;
      a = rxq.pop_front();
      chk(a == e, req, what, int'(a), int'(e));
    end
  endtask

  task automatic expect3(input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2, input string req);
    expect_one(e0, req, "report header");
    expect_one(e1, req, "report X byte");
    expect_one(e2, req, "report Y byte");
  endtask

  initial begin
    int r0, b0;
    cycles(5);
    chk(ps2_clk_oe == 1'b0 && ps2_dat_oe == 1'b0, "R1", "lines released in reset",
        int'({ps2_clk_oe, ps2_dat_oe}), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    cycles(5);
    chk(ps2_clk_oe == 1'b0 && ps2_dat_oe == 1'b0, "R1", "lines released after reset",
        int'({ps2_clk_oe, ps2_dat_oe}), 0);
    chk(mv_ready == 1'b0, "R1", "ready low after reset", int'(mv_ready), 0);

    load(10'd5, 10'd3, 1'b0, 1'b0, 1'b1, 1'b0);
    cycles(400);
    chk(total_bytes == 0 && ready_cnt == 0, "R1", "load ignored while disabled", total_bytes, 0);

    host_send(8'hF6, 1'b1);
    expect_one(8'hFA, "R4", "reply to set-defaults");
    load(10'd5, 10'd3, 1'b0, 1'b0, 1'b1, 1'b0);
    cycles(400);
    chk(total_bytes == 1 && rxq.size() == 0, "R4", "still disabled after set-defaults", total_bytes, 1);

    host_send(8'hF4, 1'b0);
    cycles(300);
    chk(total_bytes == 1, "R5", "bad parity gets no reply", total_bytes, 1);
    host_send(8'hE8, 1'b1);
    cycles(300);
    chk(total_bytes == 1, "R5", "unknown command gets no reply", total_bytes, 1);
    load(10'd5, 10'd3, 1'b0, 1'b0, 1'b1, 1'b0);
    cycles(400);
    chk(total_bytes == 1, "R5", "bad/unknown bytes left port disabled", total_bytes, 1);

    host_send(8'hF4, 1'b1);
    expect_one(8'hFA, "R4", "reply to enable");
    cycles(50);

    // Plain report, second load offered mid-report
    r0 = ready_cnt;
    b0 = total_bytes;
    load(10'd5, 10'd3, 1'b1, 1'b0, 1'b1, 1'b0);
    wait (total_bytes == b0 + 1);
    load(10'd77, 10'd66, 1'b0, 1'b1, 1'b0, 1'b1);
    expect3(8'h19, 8'h05, 8'h03, "R6");
    cycles(400);
    chk(rxq.size() == 0 && total_bytes == b0 + 3, "R9", "load during report ignored", total_bytes, b0 + 3);
    chk(ready_cnt == r0 + 1, "R9", "one ready pulse per report", ready_cnt, r0 + 1);
    chk(ready_bytes == b0 + 3, "R9", "ready after third frame", ready_bytes, b0 + 3);

    // Overflow on X
    load(10'd300, 10'd2, 1'b0, 1'b1, 1'b0, 1'b1);
    expect3(8'h6A, 8'hFF, 8'h02, "R7");
    cycles(50);
    // Overflow on Y, X overflow cleared
    load(10'd7, 10'd256, 1'b0, 1'b0, 1'b0, 1'b0);
    expect3(8'h88, 8'h07, 8'hFF, "R7");
    cycles(50);
    // Both overflow bits clear again
    load(10'd255, 10'd1, 1'b1, 1'b1, 1'b1, 1'b1);
    expect3(8'h3B, 8'hFF, 8'h01, "R7");
    cycles(50);

    // Host clock inhibit in the middle of the first byte
    b0 = total_bytes;
    load(10'h055, 10'h0AA, 1'b0, 1'b0, 1'b0, 1'b0);
    wait (mon_bitn == 3);
    wait (ps2c == 1'b1);
    @(posedge clk); #1;
    mon_ignore = 1;
    host_clk_low = 1'b1;
    cycles(3 * HALF);
    chk(ps2_clk_oe == 1'b0 && ps2_dat_oe == 1'b0, "R8", "lines released during inhibit",
        int'({ps2_clk_oe, ps2_dat_oe}), 0);
    @(posedge clk); #1;
    host_clk_low = 1'b0;
    mon_ignore = 0;
    expect3(8'h08, 8'h55, 8'hAA, "R8");
    cycles(200);
    chk(total_bytes == b0 + 3, "R8", "resent byte counted once", total_bytes, b0 + 3);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule